// File: doc/BRIEF.md
# Host Command Mailbox with Framed Responses

This block is the device side of a byte-wide host mailbox that occupies two consecutive I/O offsets. Offset 0 is the data port. On offset 1 a read returns a status byte and a write delivers a command byte. Host writes go into a small input queue. A command decoder at the head of that queue moves the device between three states: ready for a command, collecting request bytes, and waiting for the engine. While collecting, it forwards data bytes to a command-processing engine as a valid/ready byte stream. It closes the stream with an end beat and can abort it.

The engine returns its answer by announcing a byte count and then streaming the bytes. The block hands the answer to the host one byte at a time through a single output register, with in-band framing. A begin marker 0x01 comes first and an end marker 0x03 comes last, and each marker is flagged by a dedicated framing status bit. The host polls the status byte to pace both directions. By convention, bytes 2 to 5 of the engine's answer hold its total length as a big-endian 32-bit number, and an answer is at least 6 bytes long. The block relays these bytes without looking at them.

Top module: `mbx_dev`

## Requirements
- R1: After reset the status byte reads 0x10 (only the ready-for-command bit set), no request beat is offered and rsp_ready_o is low.
- R2: The status byte has these bits: bit0 output full, bit1 input full, bit2 framing flag, bit3 last host write went to offset 1, bit4 ready for a command, bit5 ready for data. Bits 6 and 7 read 0. Any host write sets bit1 for the next cycle, and bit1 clears one cycle later when the byte is consumed.
- R3: Command 0x01 written while ready for a command clears bit4 and sets bit5.
- R4: A data byte written while bit5 is set is forwarded unchanged on the request stream with req_last_o low, in write order.
- R5: Command 0x03 written while bit5 is set produces one request beat with req_last_o high and req_data_o 0x00. It then clears bit5, and bit4 stays clear until the response has been delivered.
- R6: While req_ready_i is low, a pending data byte keeps bit1 set. A command written behind it is held and acted on only after that byte is accepted. Bit1 clears once both have been consumed.
- R7: rsp_start_i, asserted while waiting for the engine, makes the status show bit2 and bit0 set and the data port read 0x01.
- R8: Reading the begin marker clears bit2 and bit0. Exactly rsp_len_i engine bytes then follow in order, each shown with bit0 set and bit2 clear. rsp_ready_o is high only while the output register is empty and bytes remain.
- R9: After the last engine byte has been read, the status shows bit2 and bit0 and the data port reads 0x03. Reading that marker returns the device to ready for a command.
- R10: A data-port read clears bit0. A status read changes no state.
- R11: Command 0x22 in any state pulses req_abort_o for one cycle. It returns the device to ready for a command and clears bit0 and bit2, which discards any partly delivered response.
- R12: A data byte written outside the collecting state, an unknown command byte, 0x01 outside the ready state and 0x03 outside the collecting state are all dropped. None of them produces a request beat or a state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hst_cs_i | input | 1 | Host access strobe, one cycle per access |
| hst_we_i | input | 1 | Host access is a write |
| hst_addr_i | input | 1 | Offset: 0 data port, 1 status/command |
| hst_wdata_i | input | 8 | Host write byte |
| hst_rdata_o | output | 8 | Host read byte (status or output register) |
| req_valid_o | output | 1 | Request beat valid |
| req_ready_i | input | 1 | Engine accepts request beat |
| req_data_o | output | 8 | Request byte |
| req_last_o | output | 1 | Beat is the end-of-request marker |
| req_abort_o | output | 1 | One-cycle pulse on a cancel command |
| rsp_start_i | input | 1 | Engine begins a response |
| rsp_len_i | input | LEN_W | Response byte count, sampled with rsp_start_i |
| rsp_valid_i | input | 1 | Engine response byte valid |
| rsp_data_i | input | 8 | Engine response byte |
| rsp_ready_o | output | 1 | Block takes the response byte this cycle |

## Verification
A decoder state that has gone wrong shows up in the status byte at the next host read, because bit4 and bit5 are taken straight from the decoder state. The same fault also shows as a missing, extra or mislabelled request beat in the cycle in which the head of the queue is consumed. A fault in the framer shows as a wrong marker byte, a framing flag on a payload byte, or a payload count that differs from rsp_len_i. The host's polling loop catches each of these within the read that follows. Faults in the hold slot show up only under back-pressure, as input-full being released too early or a command acting ahead of the data byte in front of it.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t CMD_NORMAL = 8'h01;
  localparam byte_t CMD_END    = 8'h03;
  localparam byte_t CMD_ABORT  = 8'h22;
  localparam byte_t MARK_BEGIN = 8'h01;
  localparam byte_t MARK_END   = 8'h03;

  // status bit positions, decoded by host software
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_F0  = 2;
  localparam int ST_CMD = 3;
  localparam int ST_RDY = 4;
  localparam int ST_IBR = 5;

  typedef enum logic [1:0] {C_READY, C_NORMAL, C_BUSY} ctl_state_e;
  typedef enum logic [1:0] {O_IDLE, O_HDR, O_DATA, O_END} out_phase_e;

  typedef struct packed {
    logic  cmd;
    byte_t data;
  } in_ent_t;
endpackage

// File: rtl/mbx_in_queue.sv
`timescale 1ns/1ps
module mbx_in_queue
  import mbx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_i,
  input  logic    wr_cmd_i,
  input  byte_t   wr_data_i,
  input  logic    pop_i,
  output logic    head_vld_o,
  output in_ent_t head_o,
  output logic    busy_o,
  output logic    last_cmd_o
);
  in_ent_t slot0_q, slot1_q;
  logic    vld0_q, vld1_q;
  in_ent_t wr_ent;

  assign wr_ent = '{cmd: wr_cmd_i, data: wr_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot0_q <= '0;
      slot1_q <= '0;
      vld0_q  <= 1'b0;
      vld1_q  <= 1'b0;
    end else if (pop_i && vld0_q) begin
      if (vld1_q) begin
        slot0_q <= slot1_q;
        if (wr_i) begin
          slot1_q <= wr_ent;
        end else begin
          vld1_q <= 1'b0;
        end
      end else if (wr_i) begin
        slot0_q <= wr_ent;
      end else begin
        vld0_q <= 1'b0;
      end
    end else if (wr_i) begin
      if (!vld0_q) begin
        slot0_q <= wr_ent;
        vld0_q  <= 1'b1;
      end else if (!vld1_q) begin
        slot1_q <= wr_ent;
        vld1_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   last_cmd_o <= 1'b0;
    else if (wr_i) last_cmd_o <= wr_cmd_i;
  end

  assign head_vld_o = vld0_q;
  assign head_o     = slot0_q;
  assign busy_o     = vld0_q | vld1_q;

  p_ibf_on_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> busy_o);
  p_hold_space_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !(vld0_q && vld1_q && !pop_i));
  p_pop_needs_head_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_vld_o);
endmodule

// File: rtl/mbx_ctrl.sv
`timescale 1ns/1ps
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       head_vld_i,
  input  in_ent_t    head_i,
  input  logic       req_ready_i,
  input  logic       rsp_done_i,
  output logic       pop_o,
  output logic       req_valid_o,
  output byte_t      req_data_o,
  output logic       req_last_o,
  output logic       abort_o,
  output ctl_state_e state_o
);
  ctl_state_e state_q, state_d;

  always_comb begin
    pop_o       = 1'b0;
    req_valid_o = 1'b0;
    req_last_o  = 1'b0;
    abort_o     = 1'b0;
    state_d     = state_q;
    if (head_vld_i) begin
      if (head_i.cmd) begin
        if (head_i.data == CMD_ABORT) begin
          pop_o   = 1'b1;
          abort_o = 1'b1;
          state_d = C_READY;
        end else if (head_i.data == CMD_END && state_q == C_NORMAL) begin
          req_valid_o = 1'b1;
          req_last_o  = 1'b1;
          pop_o       = req_ready_i;
          if (req_ready_i) state_d = C_BUSY;
        end else if (head_i.data == CMD_NORMAL && state_q == C_READY) begin
          pop_o   = 1'b1;
          state_d = C_NORMAL;
        end else begin
          pop_o = 1'b1;  // unknown or out-of-state command: drop
        end
      end else if (state_q == C_NORMAL) begin
        req_valid_o = 1'b1;
        pop_o       = req_ready_i;
      end else begin
        pop_o = 1'b1;    // stray data byte: drop
      end
    end
    if (state_q == C_BUSY && rsp_done_i && !abort_o) state_d = C_READY;
  end

  assign req_data_o = (head_vld_i && !head_i.cmd) ? head_i.data : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= C_READY;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_end_to_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i && req_last_o) |=> (state_o == C_BUSY));
  p_beat_pops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |-> pop_o);
  p_abort_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (state_o == C_READY));
  p_stall_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> $stable(state_o));
endmodule

// File: rtl/mbx_out.sv
`timescale 1ns/1ps
module mbx_out
  import mbx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rsp_valid_i,
  input  byte_t            rsp_data_i,
  input  logic             host_rd_i,
  input  logic             cancel_i,
  output logic             obf_o,
  output logic             f0_o,
  output byte_t            data_o,
  output logic             rsp_ready_o,
  output logic             done_o
);
  out_phase_e       phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic             obf_q, f0_q;
  byte_t            data_q;
  logic             start_ok;

  assign start_ok = arm_i && start_i && (phase_q == O_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= O_IDLE;
      cnt_q   <= '0;
      obf_q   <= 1'b0;
      f0_q    <= 1'b0;
      data_q  <= '0;
    end else if (cancel_i) begin
      phase_q <= O_IDLE;
      obf_q   <= 1'b0;
      f0_q    <= 1'b0;
    end else begin
      case (phase_q)
        O_IDLE: if (start_ok) begin
          data_q  <= MARK_BEGIN;
          obf_q   <= 1'b1;
          f0_q    <= 1'b1;
          cnt_q   <= len_i;
          phase_q <= O_HDR;
        end
        O_HDR: if (host_rd_i && obf_q) begin
          obf_q   <= 1'b0;
          f0_q    <= 1'b0;
          phase_q <= O_DATA;
        end
        O_DATA: begin
          if (obf_q) begin
            if (host_rd_i) obf_q <= 1'b0;
          end else if (cnt_q == '0) begin
            data_q  <= MARK_END;
            obf_q   <= 1'b1;
            f0_q    <= 1'b1;
            phase_q <= O_END;
          end else if (rsp_valid_i) begin
            data_q <= rsp_data_i;
            obf_q  <= 1'b1;
            cnt_q  <= cnt_q - 1'b1;
          end
        end
        O_END: if (host_rd_i && obf_q) begin
          obf_q   <= 1'b0;
          f0_q    <= 1'b0;
          phase_q <= O_IDLE;
        end
        default: phase_q <= O_IDLE;
      endcase
    end
  end

  assign rsp_ready_o = (phase_q == O_DATA) && !obf_q && (cnt_q != '0) && !cancel_i;
  assign done_o      = (phase_q == O_END) && obf_q && host_rd_i;
  assign obf_o       = obf_q;
  assign f0_o        = f0_q;
  assign data_o      = data_q;

  p_rd_clears_obf_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && obf_o) |=> !obf_o);
  p_ready_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |-> !obf_o);
  p_f0_with_obf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f0_o |-> obf_o);
  p_cancel_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> (!obf_o && !f0_o));
  p_start_marks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok && !cancel_i) |=> (f0_o && obf_o && data_o == MARK_BEGIN));
endmodule

// File: rtl/mbx_dev.sv
`timescale 1ns/1ps
module mbx_dev
  import mbx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hst_cs_i,
  input  logic             hst_we_i,
  input  logic             hst_addr_i,
  input  logic [7:0]       hst_wdata_i,
  output logic [7:0]       hst_rdata_o,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [7:0]       req_data_o,
  output logic             req_last_o,
  output logic             req_abort_o,
  input  logic             rsp_start_i,
  input  logic [LEN_W-1:0] rsp_len_i,
  input  logic             rsp_valid_i,
  input  logic [7:0]       rsp_data_i,
  output logic             rsp_ready_o
);
  logic       hst_wr, hst_rd_data;
  logic       head_vld, pop, ibf, last_cmd, abort, done;
  logic       obf, f0;
  in_ent_t    head;
  ctl_state_e state;
  byte_t      out_data, status;

  assign hst_wr      = hst_cs_i && hst_we_i;
  assign hst_rd_data = hst_cs_i && !hst_we_i && !hst_addr_i;

  mbx_in_queue u_inq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (hst_wr),
    .wr_cmd_i  (hst_addr_i),
    .wr_data_i (hst_wdata_i),
    .pop_i     (pop),
    .head_vld_o(head_vld),
    .head_o    (head),
    .busy_o    (ibf),
    .last_cmd_o(last_cmd)
  );

  mbx_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .head_vld_i (head_vld),
    .head_i     (head),
    .req_ready_i(req_ready_i),
    .rsp_done_i (done),
    .pop_o      (pop),
    .req_valid_o(req_valid_o),
    .req_data_o (req_data_o),
    .req_last_o (req_last_o),
    .abort_o    (abort),
    .state_o    (state)
  );

  mbx_out #(.LEN_W(LEN_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (state == C_BUSY),
    .start_i    (rsp_start_i),
    .len_i      (rsp_len_i),
    .rsp_valid_i(rsp_valid_i),
    .rsp_data_i (rsp_data_i),
    .host_rd_i  (hst_rd_data),
    .cancel_i   (abort),
    .obf_o      (obf),
    .f0_o       (f0),
    .data_o     (out_data),
    .rsp_ready_o(rsp_ready_o),
    .done_o     (done)
  );

  always_comb begin
    status         = '0;
    status[ST_OBF] = obf;
    status[ST_IBF] = ibf;
    status[ST_F0]  = f0;
    status[ST_CMD] = last_cmd;
    status[ST_RDY] = (state == C_READY);
    status[ST_IBR] = (state == C_NORMAL);
  end

  assign hst_rdata_o = hst_addr_i ? status : out_data;
  assign req_abort_o = abort;

  p_rdy_ibr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status[ST_RDY] && status[ST_IBR]));
  p_no_output_while_collecting_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[ST_IBR] |-> !obf);
  p_abort_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_abort_o |=> !req_abort_o || ibf);
endmodule

// File: tb/tb_mbx_dev.sv
`timescale 1ns/1ps
module tb_mbx_dev;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0, addr = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic req_valid, req_ready = 1'b1, req_last, req_abort;
  logic [7:0] req_data;
  logic rsp_start = 1'b0, rsp_ready;
  logic [LEN_W-1:0] rsp_len = '0;
  logic eng_on = 1'b0;
  logic [7:0] rsp_data;

  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  mbx_dev #(.LEN_W(LEN_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .hst_cs_i(cs), .hst_we_i(we), .hst_addr_i(addr), .hst_wdata_i(wd), .hst_rdata_o(rdata),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_data_o(req_data),
    .req_last_o(req_last), .req_abort_o(req_abort),
    .rsp_start_i(rsp_start), .rsp_len_i(rsp_len), .rsp_valid_i(eng_on),
    .rsp_data_i(rsp_data), .rsp_ready_o(rsp_ready)
  );

  // engine model: bytes 0..1 tag, 2..5 big-endian length, rest arithmetic
  function automatic logic [7:0] rsp_byte(int k, int len);
    logic [31:0] l32;
    l32 = 32'(len);
    case (k)
      0: return 8'hC4;
      1: return 8'hC1;
      2: return l32[31:24];
      3: return l32[23:16];
      4: return l32[15:8];
      5: return l32[7:0];
      default: return 8'((k * 7 + len) & 255);
    endcase
  endfunction

  int eng_cnt = 0, eng_base = 0, eng_len = 0;
  logic take = 1'b0;
  assign rsp_data = rsp_byte(eng_cnt - eng_base, eng_len);
  always @(negedge clk) take = rsp_ready & eng_on;
  always @(posedge clk) if (take) eng_cnt <= eng_cnt + 1;

  logic [7:0] cap_d [256];
  logic       cap_l [256];
  int cap_n = 0, n_abort = 0;
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      cap_d[cap_n & 255] = req_data;
      cap_l[cap_n & 255] = req_last;
      cap_n++;
    end
    if (rst_n && req_abort) n_abort++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hw(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wd = d;
    @(posedge clk);
    #1 cs = 1'b0; we = 1'b0;
  endtask

  task automatic hr(input logic a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk);
    #1 cs = 1'b0;
  endtask

  task automatic stat_is(input logic [7:0] exp, input string req);
    logic [7:0] s;
    hr(1'b1, s);
    chk(s == exp, req, s, exp);
  endtask

  task automatic eng_start(input int len);
    @(negedge clk);
    eng_base = eng_cnt; eng_len = len; eng_on = 1'b1;
    rsp_start = 1'b1; rsp_len = LEN_W'(len);
    @(posedge clk);
    #1 rsp_start = 1'b0;
  endtask

  task automatic wait_f0(output logic [7:0] s);
    for (int i = 0; i < 40; i++) begin
      hr(1'b1, s);
      if (s[2]) break;
    end
  endtask

  task automatic do_req(input int t, input int nreq);
    int base;
    base = cap_n;
    hw(1'b1, 8'h01); cyc(1);
    stat_is(8'h28, "R3 normal entry");
    for (int i = 0; i < nreq; i++) hw(1'b0, 8'((t * 31 + i * 13 + 1) & 255));
    cyc(1);
    stat_is(8'h20, "R2 data write clears bit3");
    hw(1'b1, 8'h03); cyc(1);
    chk(cap_n - base == nreq + 1, "R4 beat count", cap_n - base, nreq + 1);
    for (int i = 0; i < nreq; i++) begin
      chk(cap_d[(base + i) & 255] == 8'((t * 31 + i * 13 + 1) & 255) && !cap_l[(base + i) & 255],
          "R4 request byte", cap_d[(base + i) & 255], (t * 31 + i * 13 + 1) & 255);
    end
    chk(cap_l[(base + nreq) & 255] && cap_d[(base + nreq) & 255] == 8'h00,
        "R5 end beat", {cap_l[(base + nreq) & 255], cap_d[(base + nreq) & 255]}, 9'h100);
    stat_is(8'h08, "R5 busy status");
    hw(1'b1, 8'h01); cyc(1);
    stat_is(8'h08, "R12 normal cmd while busy ignored");
    chk(cap_n - base == nreq + 1, "R12 no extra beat", cap_n - base, nreq + 1);
  endtask

  task automatic get_rsp(input int len);
    logic [7:0] s, s2, d;
    logic [7:0] rx [64];
    int k;
    bit first;
    k = 0; first = 1'b1;
    wait_f0(s);
    chk((s & 8'h37) == 8'h05, "R7 begin status", s & 8'h37, 8'h05);
    hr(1'b0, d);
    chk(d == 8'h01, "R7 begin marker", d, 8'h01);
    for (int i = 0; i < 400; i++) begin
      hr(1'b1, s);
      if (s[0]) begin
        if (s[2]) break;
        if (first) begin
          hr(1'b1, s2);
          chk(s2 == s, "R10 status read no effect", s2, s);
        end
        hr(1'b0, d);
        chk(d == rsp_byte(k, len), "R8 payload byte", d, rsp_byte(k, len));
        if (k < 64) rx[k] = d;
        if (first) begin
          hr(1'b1, s2);
          chk(s2[0] == 1'b0, "R10 data read clears output full", s2[0], 0);
          first = 1'b0;
        end
        k++;
      end
    end
    chk(k == len, "R8 payload count", k, len);
    chk({rx[2], rx[3], rx[4], rx[5]} == 32'(len), "R8 length field",
        {rx[2], rx[3], rx[4], rx[5]}, len);
    hr(1'b0, d);
    chk(d == 8'h03, "R9 end marker", d, 8'h03);
    cyc(1);
    stat_is(8'h18, "R9 back to ready");
    eng_on = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    int base, ab;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    stat_is(8'h10, "R1 reset status");
    chk(!req_valid && !rsp_ready, "R1 idle outputs", {req_valid, rsp_ready}, 0);

    base = cap_n;
    hw(1'b0, 8'h55);
    stat_is(8'h12, "R2 write sets input full");
    stat_is(8'h10, "R2 consumed one cycle later");
    hw(1'b1, 8'h03); cyc(1);
    stat_is(8'h18, "R12 end cmd outside normal");
    hw(1'b1, 8'h5A); cyc(1);
    stat_is(8'h18, "R12 unknown cmd");
    chk(cap_n == base, "R12 no beats from dropped bytes", cap_n - base, 0);
    stat_is(8'h18, "R10 repeated status read");

    for (int t = 0; t < 10; t++) begin
      do_req(t, t + 1);
      eng_start(6 + 3 * t);
      get_rsp(6 + 3 * t);
    end

    // R6 back-pressure and held command
    base = cap_n;
    hw(1'b1, 8'h01); cyc(1);
    req_ready = 1'b0;
    hw(1'b0, 8'hA5);
    hw(1'b1, 8'h03);
    stat_is(8'h2A, "R6 held behind stalled byte");
    cyc(5);
    stat_is(8'h2A, "R6 still held");
    chk(cap_n == base, "R6 no beat while stalled", cap_n - base, 0);
    req_ready = 1'b1;
    cyc(3);
    chk(cap_n - base == 2, "R6 beats after release", cap_n - base, 2);
    chk(cap_d[base & 255] == 8'hA5 && cap_l[(base + 1) & 255], "R6 order kept",
        cap_d[base & 255], 8'hA5);
    stat_is(8'h08, "R6 input full cleared");
    ab = n_abort;
    hw(1'b1, 8'h22); cyc(2);
    chk(n_abort - ab == 1, "R11 abort pulse from busy", n_abort - ab, 1);
    stat_is(8'h18, "R11 ready after cancel");

    // R11 cancel mid-response
    do_req(10, 3);
    eng_start(12);
    wait_f0(s);
    hr(1'b0, d);
    for (int i = 0; i < 6; i++) hr(1'b1, s);
    hr(1'b0, d);
    chk(d == 8'hC4, "R8 first payload byte", d, 8'hC4);
    ab = n_abort;
    hw(1'b1, 8'h22); cyc(2);
    chk(n_abort - ab == 1, "R11 abort pulse mid-response", n_abort - ab, 1);
    stat_is(8'h18, "R11 output cleared");
    chk(!rsp_ready, "R11 no engine pull after cancel", rsp_ready, 0);
    eng_on = 1'b0;

    do_req(11, 2);
    eng_start(7);
    get_rsp(7);

    // R11 cancel while collecting
    base = cap_n; ab = n_abort;
    hw(1'b1, 8'h01);
    hw(1'b0, 8'h11);
    hw(1'b0, 8'h22);
    hw(1'b1, 8'h22); cyc(2);
    chk(n_abort - ab == 1, "R11 abort while collecting", n_abort - ab, 1);
    chk(cap_n - base == 2 && !cap_l[(base + 1) & 255], "R11 no end beat", cap_n - base, 2);
    stat_is(8'h18, "R11 ready after collecting cancel");

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule